// File: doc/BRIEF.md
# Instruction Operand Decoder and Address Generator

This block turns one 6-bit operand specifier of a 16-bit instruction into a resolved operand. The operand can be a general register, a memory location, a stack slot, one of the special registers (stack pointer, program counter, overflow register) or a literal. It is purely combinational. A sequencer presents one slot at a time, the source slot first and the destination slot second. For each slot the block returns the operand kind, a direct value (registers, special registers and literals) or a memory address, and the stack pointer and program counter that follow once the slot is resolved.

When an operand needs an extra instruction word, the block raises a request and reports the fetch address, which is the current program counter, together with the incremented program counter. The sequencer supplies the fetched word on `next_word`. The block also reports the extra cycles the operand costs. It flags literal operands so that any write aimed at them is discarded. The destination slot carries only five code bits, and its top bit is taken as zero.

Top module: `opd_decoder`

## Requirements
- R1: Codes 0x00-0x07 give kind 0 (register) with `value` equal to register index code[2:0] (0=A,1=B,2=C,3=X,4=Y,5=Z,6=I,7=J, register k at `reg_file[16k+15:16k]`), and `mem_en` 0.
- R2: Codes 0x08-0x0f give kind 2 (memory) with `mem_en` 1 and `mem_addr` equal to the register selected by code[2:0].
- R3: Codes 0x10-0x17 give kind 2 with `mem_addr` equal to the selected register plus `next_word`, modulo 2^16.
- R4: Code 0x18 gives kind 2. In the destination slot `mem_addr` and `sp_next` are both SP-1. In the source slot `mem_addr` is SP and `sp_next` is SP+1. All SP arithmetic wraps modulo 2^16, so a push from SP=0 addresses 0xffff.
- R5: Code 0x19 gives kind 2 at address SP. Code 0x1a gives kind 2 at address SP+`next_word`.
- R6: Codes 0x1b, 0x1c and 0x1d give kind 1 (special) with `value` equal to SP, PC and EX respectively.
- R7: Code 0x1e gives kind 2 at address `next_word`. Code 0x1f gives kind 3 (literal) with `value` equal to `next_word`.
- R8: In the source slot, codes 0x20-0x3f give kind 3 with `value` equal to code minus 0x21 modulo 2^16 (0x20 gives 0xffff, 0x3f gives 30) and request no word.
- R9: In the destination slot only code[4:0] is decoded, so code C with bit 5 set behaves exactly like C-0x20 and never yields an inline literal.
- R10: `write_drop` is 1 exactly when the kind is 3 (literal), in either slot.
- R11: `word_req` is 1 for codes 0x10-0x17, 0x1a, 0x1e and 0x1f. When it is 1, `word_addr` equals PC, `pc_next` equals PC+1 and `extra_cycles` is 1. Otherwise `pc_next` equals PC and `extra_cycles` is 0.
- R12: `sp_write` is 1 only for code 0x18. For all other codes `sp_next` equals SP.
- R13: For kind 2, `value` is 0. For kinds other than 2, `mem_en` is 0 and `mem_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| is_dst | input | 1 | 1 when the presented code is the destination slot |
| code | input | 6 | operand specifier |
| reg_file | input | 128 | eight 16-bit general registers, A in the low word |
| sp | input | 16 | current stack pointer |
| pc | input | 16 | program counter pointing at the next unread word |
| ex | input | 16 | overflow register |
| next_word | input | 16 | extra instruction word read at `word_addr` |
| kind | output | 2 | 0 register, 1 special, 2 memory, 3 literal |
| value | output | 16 | direct operand value for kinds 0, 1 and 3 |
| mem_en | output | 1 | operand lives in memory |
| mem_addr | output | 16 | memory address of the operand |
| word_req | output | 1 | an extra instruction word is consumed |
| word_addr | output | 16 | address of the extra word |
| pc_next | output | 16 | program counter after this slot |
| sp_write | output | 1 | stack pointer changes |
| sp_next | output | 16 | stack pointer after this slot |
| extra_cycles | output | 2 | cycles this operand adds |
| write_drop | output | 1 | writes to this operand are discarded |

## Verification
The bench builds the decoder with its default 16-bit word and eight registers. At that size the full code space, 64 codes in both slots, can be swept against every stack pointer pattern. The patterns include SP at 0 and at 0xffff, so the wrap of push and pop is reached directly. Register, word and PC values vary per pattern so that sums such as register plus word overflow 16 bits in some vectors.

// File: rtl/opd_pkg.sv
package opd_pkg;

   typedef enum logic [1:0] {
      OK_REG  = 2'd0,
      OK_SPEC = 2'd1,
      OK_MEM  = 2'd2,
      OK_LIT  = 2'd3
   } opd_kind_e;

   typedef struct packed {
      opd_kind_e  kind;
      logic       base_reg;
      logic       base_sp;
      logic       add_word;
      logic       push;
      logic       pop;
      logic [1:0] spec;
      logic [4:0] lit;
      logic       need_word;
   } opd_class_t;

endpackage

// File: rtl/opd_class.sv
module opd_class
   import opd_pkg::*;
#(
   parameter int CW = 6
) (
   input  logic          is_dst,
   input  logic [CW-1:0] code,
   output opd_class_t    cls
);
   localparam int DCW = CW - 1;

   logic [CW-1:0] eff;

   // destination slot has one bit fewer: zero-extend it
   assign eff = is_dst ? {1'b0, code[DCW-1:0]} : code;

   always_comb begin
      cls = '0;
      cls.kind = OK_REG;
      if (eff[CW-1]) begin
         cls.kind = OK_LIT;
         cls.lit  = eff[4:0];
      end else begin
         unique case (eff[4:3])
            2'd0: cls.kind = OK_REG;
            2'd1: begin
               cls.kind     = OK_MEM;
               cls.base_reg = 1'b1;
            end
            2'd2: begin
               cls.kind      = OK_MEM;
               cls.base_reg  = 1'b1;
               cls.add_word  = 1'b1;
               cls.need_word = 1'b1;
            end
            default: begin
               unique case (eff[2:0])
                  3'd0: begin
                     cls.kind    = OK_MEM;
                     cls.base_sp = 1'b1;
                     cls.push    = is_dst;
                     cls.pop     = !is_dst;
                  end
                  3'd1: begin
                     cls.kind    = OK_MEM;
                     cls.base_sp = 1'b1;
                  end
                  3'd2: begin
                     cls.kind      = OK_MEM;
                     cls.base_sp   = 1'b1;
                     cls.add_word  = 1'b1;
                     cls.need_word = 1'b1;
                  end
                  3'd3: begin
                     cls.kind = OK_SPEC;
                     cls.spec = 2'd0;
                  end
                  3'd4: begin
                     cls.kind = OK_SPEC;
                     cls.spec = 2'd1;
                  end
                  3'd5: begin
                     cls.kind = OK_SPEC;
                     cls.spec = 2'd2;
                  end
                  3'd6: begin
                     cls.kind      = OK_MEM;
                     cls.add_word  = 1'b1;
                     cls.need_word = 1'b1;
                  end
                  default: begin
                     cls.kind      = OK_LIT;
                     cls.need_word = 1'b1;
                  end
               endcase
            end
         endcase
      end
   end

   // R9: a destination slot never decodes as an inline literal
   always_comb begin
      if (!$isunknown({is_dst, code}) && is_dst && cls.kind == OK_LIT)
         a_r9_dst_no_inline: assert (cls.need_word);
   end
endmodule

// File: rtl/opd_stack.sv
module opd_stack #(
   parameter int DW = 16
) (
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] sp,
   output logic [DW-1:0] stack_addr,
   output logic [DW-1:0] sp_next,
   output logic          sp_write
);
   logic [DW-1:0] sp_dec;
   logic [DW-1:0] sp_inc;

   assign sp_dec     = sp - DW'(1);
   assign sp_inc     = sp + DW'(1);
   assign stack_addr = push ? sp_dec : sp;
   assign sp_next    = push ? sp_dec : (pop ? sp_inc : sp);
   assign sp_write   = push | pop;

   // R4: a push and a pop are never requested together
   always_comb begin
      if (!$isunknown({push, pop}))
         a_r4_push_pop_excl: assert (!(push && pop));
   end
endmodule

// File: rtl/opd_addr.sv
module opd_addr #(
   parameter int DW   = 16,
   parameter int NREG = 8
) (
   input  logic [$clog2(NREG)-1:0] ridx,
   input  logic [NREG*DW-1:0]      reg_file,
   input  logic                    base_reg,
   input  logic                    base_sp,
   input  logic                    add_word,
   input  logic [DW-1:0]           stack_addr,
   input  logic [DW-1:0]           next_word,
   output logic [DW-1:0]           reg_val,
   output logic [DW-1:0]           addr
);
   logic [DW-1:0] regs [NREG];

   for (genvar k = 0; k < NREG; k++) begin : g_unpack
      assign regs[k] = reg_file[k*DW +: DW];
   end

   assign reg_val = regs[ridx];
   assign addr    = (base_reg ? reg_val    : '0)
                  + (base_sp  ? stack_addr : '0)
                  + (add_word ? next_word  : '0);
endmodule

// File: rtl/opd_decoder.sv
module opd_decoder
   import opd_pkg::*;
#(
   parameter int DW   = 16,
   parameter int NREG = 8,
   parameter int CW   = 6
) (
   input  logic             is_dst,
   input  logic [CW-1:0]    code,
   input  logic [NREG*DW-1:0] reg_file,
   input  logic [DW-1:0]    sp,
   input  logic [DW-1:0]    pc,
   input  logic [DW-1:0]    ex,
   input  logic [DW-1:0]    next_word,
   output logic [1:0]       kind,
   output logic [DW-1:0]    value,
   output logic             mem_en,
   output logic [DW-1:0]    mem_addr,
   output logic             word_req,
   output logic [DW-1:0]    word_addr,
   output logic [DW-1:0]    pc_next,
   output logic             sp_write,
   output logic [DW-1:0]    sp_next,
   output logic [1:0]       extra_cycles,
   output logic             write_drop
);
   localparam int RIDX = $clog2(NREG);

   if (NREG != 8) begin : g_bad_nreg
      $error("opd_decoder: register field is 3 bits, NREG must be 8");
   end
   if (CW != 6) begin : g_bad_cw
      $error("opd_decoder: operand code must be 6 bits");
   end
   if (DW < 8) begin : g_bad_dw
      $error("opd_decoder: word width too small for inline literals");
   end

   opd_class_t    cls;
   logic [DW-1:0] stack_addr;
   logic [DW-1:0] reg_val;
   logic [DW-1:0] addr;
   logic [DW-1:0] spec_val;
   logic [DW-1:0] lit_val;

   opd_class #(.CW(CW)) u_class (
      .is_dst (is_dst),
      .code   (code),
      .cls    (cls)
   );

   opd_stack #(.DW(DW)) u_stack (
      .push       (cls.push),
      .pop        (cls.pop),
      .sp         (sp),
      .stack_addr (stack_addr),
      .sp_next    (sp_next),
      .sp_write   (sp_write)
   );

   opd_addr #(.DW(DW), .NREG(NREG)) u_addr (
      .ridx       (code[RIDX-1:0]),
      .reg_file   (reg_file),
      .base_reg   (cls.base_reg),
      .base_sp    (cls.base_sp),
      .add_word   (cls.add_word),
      .stack_addr (stack_addr),
      .next_word  (next_word),
      .reg_val    (reg_val),
      .addr       (addr)
   );

   always_comb begin
      unique case (cls.spec)
         2'd0:    spec_val = sp;
         2'd1:    spec_val = pc;
         default: spec_val = ex;
      endcase
   end

   // inline literal: code minus 0x21, i.e. low five bits minus one
   assign lit_val = cls.need_word ? next_word : (DW'(cls.lit) - DW'(1));

   always_comb begin
      unique case (cls.kind)
         OK_REG:  value = reg_val;
         OK_SPEC: value = spec_val;
         OK_LIT:  value = lit_val;
         default: value = '0;
      endcase
   end

   assign kind         = cls.kind;
   assign mem_en       = (cls.kind == OK_MEM);
   assign mem_addr     = mem_en ? addr : '0;
   assign word_req     = cls.need_word;
   assign word_addr    = pc;
   assign pc_next      = pc + DW'(cls.need_word);
   assign extra_cycles = {1'b0, cls.need_word};
   assign write_drop   = (cls.kind == OK_LIT);

   always_comb begin
      if (!$isunknown({is_dst, code, pc, sp})) begin
         // R11: program counter advances by exactly the words consumed
         a_r11_pc_step: assert (pc_next == (word_req ? pc + DW'(1) : pc));
         // R11: cost matches the extra word
         a_r11_cost: assert (extra_cycles == {1'b0, word_req});
         // R12: stack pointer moves by one only when written
         a_r12_sp_step: assert (sp_write ? (sp_next == sp + DW'(1) || sp_next == sp - DW'(1))
                                         : (sp_next == sp));
         // R10: a dropped write never targets memory
         a_r10_drop_nomem: assert (!(write_drop && mem_en));
         // R13: memory address is quiet for non-memory operands
         a_r13_addr_quiet: assert (mem_en || mem_addr == '0);
      end
   end
endmodule

// File: tb/opd_decoder_bench.sv
module opd_decoder_bench;
   localparam int DW = 16;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic            is_dst;
   logic [5:0]      code;
   logic [8*DW-1:0] reg_file;
   logic [DW-1:0]   sp, pc, ex, next_word;
   logic [1:0]      kind;
   logic [DW-1:0]   value, mem_addr, word_addr, pc_next, sp_next;
   logic            mem_en, word_req, sp_write, write_drop;
   logic [1:0]      extra_cycles;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;
   bit done = 0;

   opd_decoder u_opd_decoder (
      .is_dst(is_dst), .code(code), .reg_file(reg_file), .sp(sp), .pc(pc),
      .ex(ex), .next_word(next_word), .kind(kind), .value(value),
      .mem_en(mem_en), .mem_addr(mem_addr), .word_req(word_req),
      .word_addr(word_addr), .pc_next(pc_next), .sp_write(sp_write),
      .sp_next(sp_next), .extra_cycles(extra_cycles), .write_drop(write_drop)
   );

   task automatic check(input string tag, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s dst=%0b code=%02h actual=%04h expected=%04h",
                  tag, what, is_dst, code, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] rget(input int k);
      return reg_file[k*DW +: DW];
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] sps [4] = '{16'h0000, 16'hffff, 16'h1234, 16'h8000};
      for (int p = 0; p < 4; p++) begin
         sp        = sps[p];
         pc        = 16'hfffe + DW'(p * 16'h0101);
         ex        = 16'h5a5a ^ DW'(p);
         next_word = 16'hf00d + DW'(p * 16'h2222);
         for (int k = 0; k < 8; k++)
            reg_file[k*DW +: DW] = 16'h0f10 * DW'(k + 1) + DW'(p * 16'h3333);
         for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 64; c++) begin
               logic [5:0]    e;
               logic [1:0]    ek;
               logic [DW-1:0] ev, ea, esp;
               logic          ew, esw;
               string         tg;
               is_dst = (s == 1);
               code   = 6'(c);
               e   = is_dst ? {1'b0, code[4:0]} : code;
               ek  = 2'd0; ev = '0; ea = '0; ew = 1'b0; esw = 1'b0; esp = sp;
               tg  = "R1";
               if (e >= 6'h20) begin
                  ek = 2'd3; ev = DW'(e) - 16'h0021; tg = "R8";
               end else if (e < 6'h08) begin
                  ev = rget(int'(e[2:0]));
               end else if (e < 6'h10) begin
                  ek = 2'd2; ea = rget(int'(e[2:0])); tg = "R2";
               end else if (e < 6'h18) begin
                  ek = 2'd2; ea = rget(int'(e[2:0])) + next_word; ew = 1'b1; tg = "R3";
               end else begin
                  case (e)
                     6'h18: begin
                        ek = 2'd2; esw = 1'b1; tg = "R4";
                        ea  = is_dst ? sp - 16'd1 : sp;
                        esp = is_dst ? sp - 16'd1 : sp + 16'd1;
                     end
                     6'h19: begin ek = 2'd2; ea = sp; tg = "R5"; end
                     6'h1a: begin ek = 2'd2; ea = sp + next_word; ew = 1'b1; tg = "R5"; end
                     6'h1b: begin ek = 2'd1; ev = sp; tg = "R6"; end
                     6'h1c: begin ek = 2'd1; ev = pc; tg = "R6"; end
                     6'h1d: begin ek = 2'd1; ev = ex; tg = "R6"; end
                     6'h1e: begin ek = 2'd2; ea = next_word; ew = 1'b1; tg = "R7"; end
                     default: begin ek = 2'd3; ev = next_word; ew = 1'b1; tg = "R7"; end
                  endcase
               end
               if (is_dst && code[5]) tg = {tg, "/R9"};
               #5;
               check(tg, "kind", DW'(kind), DW'(ek));
               check(tg, "value", value, ev);
               check("R13", "mem_en", DW'(mem_en), DW'(ek == 2'd2));
               check(tg, "mem_addr", mem_addr, ea);
               check("R11", "word_req", DW'(word_req), DW'(ew));
               if (ew) check("R11", "word_addr", word_addr, pc);
               check("R11", "pc_next", pc_next, pc + DW'(ew));
               check("R11", "extra_cycles", DW'(extra_cycles), DW'(ew));
               check("R12", "sp_write", DW'(sp_write), DW'(esw));
               check(esw ? "R4" : "R12", "sp_next", sp_next, esp);
               check("R10", "write_drop", DW'(write_drop), DW'(ek == 2'd3));
            end
         end
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule